// File: doc/BRIEF.md
# Linked-Descriptor Scatter/Gather Sequencer

This block drives up to four DMA channel engines from chains of descriptors held in memory. Software writes a channel's head pointer with the address of the first descriptor, then sets that channel's start bit through a masked command write. The channel's sequencer reads the five descriptor words one after another, hands the descriptor to its engine with a one-cycle go pulse, and waits for the engine to report done. If the descriptor's link bit is set, the sequencer loads the next-descriptor address into its pointer and fetches again. If the link bit is clear, the chain ends.

At the end of each descriptor, a per-channel interrupt pulse is raised when the engine's completion cause matches an interrupt-enable bit carried in that descriptor. Software can clear the start bit to stop a chain at the next safe point. The pointer stays on the descriptor that was in progress, so software can work out how much is left. All channels share one descriptor read port through a fixed-priority arbiter that keeps one read in flight.

The data mover itself lies outside this block. It is seen only as an engine that takes a descriptor and later pulses done with a cause.

Top module: `sg_chain_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_req`, `eng_go`, `irq` and `sg_busy` are all zero, and every `cur_ptr` lane is zero.
- R2: A command write (`cmd_we`) changes channel i's start bit only when `cmd_mask[i]` is 1 in the same write. In a software-visible command word, start bit i sits at bit 31-i and its mask at bit 15-i. A write without the mask leaves the channel idle and starts no read.
- R3: Setting a start bit on an idle channel reads five words from consecutive word addresses `ptr`, `ptr+4`, `ptr+8`, `ptr+12`, `ptr+16`. These are the control word, source, destination, control/count word and next pointer. `eng_go` pulses only after the fifth word is taken. It presents them on `eng_ctrl`, `eng_src`, `eng_dst` and `eng_ccnt`, with the transfer count in `eng_ccnt[15:0]`.
- R4: After done, if bit 31 (link) of the control/count word is 1, `cur_ptr` takes the next-pointer word and fetching repeats. If it is 0, the chain ends and `cur_ptr` keeps the address of that last descriptor.
- R5: One cycle after done, `irq[i]` pulses for exactly one cycle if and only if `cause & ccnt[29:27]` is non-zero. Bit 29 enables terminal count, bit 28 end-of-transfer and bit 27 error. The cause encoding is `eng_cause[3i+2]` = terminal count, `[3i+1]` = end-of-transfer, `[3i]` = error.
- R6: `sg_busy[i]` goes high in the cycle after the start write and stays high until the chain ends.
- R7: Clearing the start bit during a fetch lets that fetch finish. No `eng_go` follows, the channel goes idle, and `cur_ptr` keeps the descriptor's address.
- R8: Clearing the start bit during a transfer waits for done. No further descriptor is fetched, and `cur_ptr` keeps the current descriptor's address.
- R9: A head-pointer write is ignored while the channel is busy and takes effect when it is idle.
- R10: Only one descriptor read is in flight. `rd_addr` holds steady until `rd_ack`. On contention the lowest-numbered channel is served first, and concurrent chains all complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_start | input | NCH | Start-bit values being written, bit i = channel i |
| cmd_mask | input | NCH | Per-channel write enables for the start bits |
| hp_we | input | 1 | Head-pointer write strobe |
| hp_sel | input | CH_W | Channel whose head pointer is written |
| hp_wdata | input | 32 | Head-pointer value |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the word being read |
| rd_ack | input | 1 | Memory accepts the read; `rd_data` is valid |
| rd_data | input | 32 | Descriptor word |
| eng_go | output | NCH | One-cycle start pulse per engine |
| eng_ctrl | output | NCH*32 | Descriptor control word per engine |
| eng_src | output | NCH*32 | Source address per engine |
| eng_dst | output | NCH*32 | Destination address per engine |
| eng_ccnt | output | NCH*32 | Control/count word per engine |
| eng_done | input | NCH | Engine completion pulse |
| eng_cause | input | NCH*3 | Completion cause per engine {tc, eot, err} |
| irq | output | NCH | Per-channel descriptor interrupt pulse |
| sg_busy | output | NCH | Chain in progress |
| cur_ptr | output | NCH*32 | Current descriptor address |

## Verification
A sequencer stuck in the wrong state shows at the ports within one cycle. `rd_req` stays high with no fetch due, or `sg_busy` disagrees with the chain's progress. A wrong word index shows on the first fetch as an out-of-order `rd_addr`, or as wrong fields at `eng_go`. A lost halt or lost link bit shows one descriptor later as an extra or missing `eng_go` and a `cur_ptr` that differs from the expected descriptor. A mis-decoded interrupt enable shows as a missing or spurious `irq` one cycle after done.

// File: rtl/sgseq_pkg.sv
package sgseq_pkg;
    localparam int ADDR_W     = 32;
    localparam int DESC_WORDS = 5;
    localparam int LINK_BIT   = 31;
    localparam int TCI_BIT    = 29;
    localparam int ERI_BIT    = 27;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ctrl;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] ccnt;
        logic [ADDR_W-1:0] next;
    } desc_t;

    // Interrupt when a completion cause bit meets its enable in the descriptor.
    function automatic logic irq_hit(logic [ADDR_W-1:0] ccnt, logic [2:0] cause);
        return |(cause & ccnt[TCI_BIT:ERI_BIT]);
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, logic [2:0] idx);
        return base + {{(ADDR_W-5){1'b0}}, idx, 2'b00};
    endfunction
endpackage

// File: rtl/sgseq_rd_arb.sv
module sgseq_rd_arb
    import sgseq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        req,
    input  logic [NCH*ADDR_W-1:0] addr,
    output logic [NCH-1:0]        ack,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_ack
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [SEL_W-1:0] pick, sel, own_q;
    logic             lock_q;

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = SEL_W'(i);
        end
    end

    assign sel     = lock_q ? own_q : pick;
    assign rd_req  = req[sel];
    assign rd_addr = addr[sel*ADDR_W +: ADDR_W];

    always_comb begin
        ack = '0;
        ack[sel] = rd_ack & rd_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            own_q  <= '0;
        end else if (rd_req && !rd_ack) begin
            lock_q <= 1'b1;
            own_q  <= sel;
        end else if (rd_ack) begin
            lock_q <= 1'b0;
        end
    end

    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));
    assert_addr_held_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
endmodule

// File: rtl/sgseq_chan.sv
module sgseq_chan
    import sgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              hp_we,
    input  logic [ADDR_W-1:0] hp_wdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [ADDR_W-1:0] rd_data,
    output logic              go,
    output desc_t             desc,
    input  logic              done,
    input  logic [2:0]        cause,
    output logic              irq,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [2:0] LAST_IDX = 3'(DESC_WORDS - 1);

    seq_state_e state;
    logic [2:0] idx;
    logic       halt_q;

    assign rd_req  = (state == ST_FETCH);
    assign rd_addr = word_addr(ptr, idx);
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            halt_q <= 1'b0;
            ptr    <= '0;
            go     <= 1'b0;
            irq    <= 1'b0;
            desc   <= '0;
        end else begin
            go  <= 1'b0;
            irq <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hp_we) ptr <= hp_wdata;
                    if (start_set) begin
                        state  <= ST_FETCH;
                        idx    <= '0;
                        halt_q <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (start_clr) halt_q <= 1'b1;
                    if (rd_ack) begin
                        case (idx)
                            3'd0:    desc.ctrl <= rd_data;
                            3'd1:    desc.src  <= rd_data;
                            3'd2:    desc.dst  <= rd_data;
                            3'd3:    desc.ccnt <= rd_data;
                            default: desc.next <= rd_data;
                        endcase
                        if (idx == LAST_IDX) begin
                            if (halt_q || start_clr) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_XFER;
                                go    <= 1'b1;
                            end
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                end
                ST_XFER: begin
                    if (start_clr) halt_q <= 1'b1;
                    if (done) begin
                        irq <= irq_hit(desc.ccnt, cause);
                        if (halt_q || start_clr || !desc.ccnt[LINK_BIT]) begin
                            state <= ST_IDLE;
                        end else begin
                            ptr   <= desc.next;
                            idx   <= '0;
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_go_after_fifth_word_R3: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(state == ST_FETCH && rd_ack && idx == LAST_IDX));
    assert_irq_follows_done_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(done && state == ST_XFER));
    assert_no_go_after_halt_R7: assert property (@(posedge clk) disable iff (rst)
        go |-> $past(!halt_q && !start_clr));
    assert_ptr_steady_in_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        $past(state == ST_FETCH) |-> $stable(ptr));
endmodule

// File: rtl/sg_chain_seq.sv
module sg_chain_seq
    import sgseq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_we,
    input  logic [NCH-1:0]        cmd_start,
    input  logic [NCH-1:0]        cmd_mask,
    input  logic                  hp_we,
    input  logic [CH_W-1:0]       hp_sel,
    input  logic [ADDR_W-1:0]     hp_wdata,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic                  rd_ack,
    input  logic [ADDR_W-1:0]     rd_data,
    output logic [NCH-1:0]        eng_go,
    output logic [NCH*ADDR_W-1:0] eng_ctrl,
    output logic [NCH*ADDR_W-1:0] eng_src,
    output logic [NCH*ADDR_W-1:0] eng_dst,
    output logic [NCH*ADDR_W-1:0] eng_ccnt,
    input  logic [NCH-1:0]        eng_done,
    input  logic [NCH*3-1:0]      eng_cause,
    output logic [NCH-1:0]        irq,
    output logic [NCH-1:0]        sg_busy,
    output logic [NCH*ADDR_W-1:0] cur_ptr
);
    logic [NCH-1:0]        ch_req, ch_ack;
    logic [NCH*ADDR_W-1:0] ch_addr;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic  set_i, clr_i, hp_i;
        desc_t d_i;

        assign set_i = cmd_we && cmd_mask[i] && cmd_start[i];
        assign clr_i = cmd_we && cmd_mask[i] && !cmd_start[i];
        assign hp_i  = hp_we && (hp_sel == CH_W'(i));

        sgseq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .start_set (set_i),
            .start_clr (clr_i),
            .hp_we     (hp_i),
            .hp_wdata  (hp_wdata),
            .rd_req    (ch_req[i]),
            .rd_addr   (ch_addr[i*ADDR_W +: ADDR_W]),
            .rd_ack    (ch_ack[i]),
            .rd_data   (rd_data),
            .go        (eng_go[i]),
            .desc      (d_i),
            .done      (eng_done[i]),
            .cause     (eng_cause[i*3 +: 3]),
            .irq       (irq[i]),
            .busy      (sg_busy[i]),
            .ptr       (cur_ptr[i*ADDR_W +: ADDR_W])
        );

        assign eng_ctrl[i*ADDR_W +: ADDR_W] = d_i.ctrl;
        assign eng_src [i*ADDR_W +: ADDR_W] = d_i.src;
        assign eng_dst [i*ADDR_W +: ADDR_W] = d_i.dst;
        assign eng_ccnt[i*ADDR_W +: ADDR_W] = d_i.ccnt;
    end

    sgseq_rd_arb #(.NCH(NCH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (ch_req),
        .addr    (ch_addr),
        .ack     (ch_ack),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_ack  (rd_ack)
    );

    assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_we && (cmd_mask & cmd_start & ~sg_busy) != '0 |=> (sg_busy != '0));
endmodule

// File: tb/sg_chain_seq_bench.sv
module sg_chain_seq_bench;
    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_we = 1'b0;
    logic [NCH-1:0]    cmd_start = '0, cmd_mask = '0;
    logic              hp_we = 1'b0;
    logic [1:0]        hp_sel = '0;
    logic [31:0]       hp_wdata = '0;
    logic              rd_req, rd_ack;
    logic [31:0]       rd_addr, rd_data;
    logic [NCH-1:0]    eng_go, eng_done, irq, sg_busy;
    logic [NCH*32-1:0] eng_ctrl, eng_src, eng_dst, eng_ccnt, cur_ptr;
    logic [NCH*3-1:0]  eng_cause;
    logic              stall = 1'b0;

    logic [31:0] mem [0:1023];
    int          go_cnt [NCH];
    int          irq_cnt[NCH];
    int          rem    [NCH];
    logic [NCH-1:0] act = '0;
    logic [2:0]  cause_cfg [NCH];
    logic [31:0] last_src [NCH];
    logic [31:0] last_dst [NCH];
    logic [31:0] last_ctrl[NCH];
    logic [31:0] last_ccnt[NCH];
    logic [31:0] log_a [0:255];
    int          log_n = 0;
    int          checks = 0, errors = 0;

    // ndesc, count, enables {tc,eot,err}, engine cause, expected irq pulses
    localparam int VN [6] = '{1, 3, 2, 4, 2, 3};
    localparam int VC [6] = '{3, 2, 5, 1, 4, 0};
    localparam int VEN[6] = '{4, 4, 3, 0, 1, 7};
    localparam int VCA[6] = '{4, 2, 2, 7, 1, 4};
    localparam int VX [6] = '{1, 0, 2, 0, 2, 3};

    sg_chain_seq u_sg_chain_seq (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_mask(cmd_mask),
        .hp_we(hp_we), .hp_sel(hp_sel), .hp_wdata(hp_wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .eng_go(eng_go), .eng_ctrl(eng_ctrl), .eng_src(eng_src), .eng_dst(eng_dst),
        .eng_ccnt(eng_ccnt), .eng_done(eng_done), .eng_cause(eng_cause),
        .irq(irq), .sg_busy(sg_busy), .cur_ptr(cur_ptr)
    );

    always #5 clk = ~clk;

    assign rd_ack  = rd_req & ~stall;
    assign rd_data = mem[rd_addr[11:2]];
    for (genvar g = 0; g < NCH; g++) begin : g_cause
        assign eng_cause[g*3 +: 3] = cause_cfg[g];
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            go_cnt[i] = 0; irq_cnt[i] = 0; rem[i] = 0; cause_cfg[i] = 3'b100;
            last_src[i] = '0; last_dst[i] = '0; last_ctrl[i] = '0; last_ccnt[i] = '0;
        end
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    end

    // Engine model: done pulses count cycles after go (count 0 acts as 1).
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            eng_done[i] <= 1'b0;
            if (eng_go[i]) begin
                go_cnt[i]    <= go_cnt[i] + 1;
                rem[i]       <= (eng_ccnt[i*32 +: 16] == 16'd0) ? 1 : int'(eng_ccnt[i*32 +: 16]);
                act[i]       <= 1'b1;
                last_src[i]  <= eng_src[i*32 +: 32];
                last_dst[i]  <= eng_dst[i*32 +: 32];
                last_ctrl[i] <= eng_ctrl[i*32 +: 32];
                last_ccnt[i] <= eng_ccnt[i*32 +: 32];
            end else if (act[i]) begin
                if (rem[i] <= 1) begin
                    eng_done[i] <= 1'b1;
                    act[i]      <= 1'b0;
                end else begin
                    rem[i] <= rem[i] - 1;
                end
            end
            if (irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
        end
        if (rd_req && rd_ack) begin
            log_a[log_n[7:0]] <= rd_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic build(input int base, input int n, input int cnt, input int en);
        for (int k = 0; k < n; k++) begin
            int a = (base + 20 * k) >> 2;
            mem[a]     = 32'hC000_0000 | k;
            mem[a + 1] = 32'h0001_0000 + base + k;
            mem[a + 2] = 32'h0002_0000 + base + k;
            mem[a + 3] = ((k < n - 1) ? 32'h8000_0000 : 32'h0) | (32'(en) << 27) | 32'(cnt & 16'hFFFF);
            mem[a + 4] = 32'(base + 20 * (k + 1));
        end
    endtask

    task automatic set_hp(input int ch, input int val);
        @(negedge clk);
        hp_we = 1'b1; hp_sel = 2'(ch); hp_wdata = 32'(val);
        @(negedge clk);
        hp_we = 1'b0;
    endtask

    task automatic cmd(input logic [3:0] st, input logic [3:0] mk);
        @(negedge clk);
        cmd_we = 1'b1; cmd_start = st; cmd_mask = mk;
        @(negedge clk);
        cmd_we = 1'b0; cmd_start = '0; cmd_mask = '0;
    endtask

    task automatic wait_idle(input int ch);
        int n = 0;
        while (sg_busy[ch] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!sg_busy[ch], "R6 chain did not end", longint'(sg_busy[ch]), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int g0, i0, mark, base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_req == 1'b0, "R1 rd_req in reset", longint'(rd_req), 0);
        chk(sg_busy == '0 && eng_go == '0 && irq == '0, "R1 outputs in reset", longint'({sg_busy, eng_go, irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cur_ptr == '0 && sg_busy == '0, "R1 after reset", longint'(cur_ptr[31:0]), 0);

        // Vector table walk on channel 0
        for (int v = 0; v < 6; v++) begin
            base = 32'h100 * (v + 1);
            build(base, VN[v], VC[v], VEN[v]);
            cause_cfg[0] = 3'(VCA[v]);
            set_hp(0, base);
            g0 = go_cnt[0]; i0 = irq_cnt[0]; mark = log_n;
            cmd(4'b0001, 4'b0001);
            chk(sg_busy[0] == 1'b1, "R6 busy after start", longint'(sg_busy[0]), 1);
            wait_idle(0);
            for (int k = 0; k < 5; k++)
                chk(log_a[8'(mark + k)] == 32'(base + 4 * k), "R3 fetch order",
                    longint'(log_a[8'(mark + k)]), longint'(base + 4 * k));
            chk(go_cnt[0] - g0 == VN[v], "R4 descriptors run", go_cnt[0] - g0, VN[v]);
            chk(irq_cnt[0] - i0 == VX[v], "R5 interrupt pulses", irq_cnt[0] - i0, VX[v]);
            chk(cur_ptr[31:0] == 32'(base + 20 * (VN[v] - 1)), "R4 final pointer",
                longint'(cur_ptr[31:0]), longint'(base + 20 * (VN[v] - 1)));
            chk(last_src[0] == 32'h0001_0000 + 32'(base + VN[v] - 1), "R3 source field",
                longint'(last_src[0]), longint'(32'h0001_0000 + base + VN[v] - 1));
            chk(last_dst[0] == 32'h0002_0000 + 32'(base + VN[v] - 1) &&
                last_ctrl[0] == (32'hC000_0000 | 32'(VN[v] - 1)) &&
                last_ccnt[0][15:0] == 16'(VC[v]), "R3 dst/ctrl/count fields",
                longint'(last_ccnt[0]), longint'(VC[v]));
        end

        // R2: start bit without its mask does nothing
        g0 = go_cnt[0]; mark = log_n;
        cmd(4'b0001, 4'b0000);
        repeat (4) @(negedge clk);
        chk(sg_busy == '0 && log_n == mark, "R2 unmasked start ignored", longint'(sg_busy), 0);
        chk(go_cnt[0] == g0, "R2 no transfer", go_cnt[0], g0);

        // R7: halt during a stalled fetch
        build(32'h800, 2, 4, 4);
        set_hp(0, 32'h800);
        g0 = go_cnt[0];
        stall = 1'b1;
        cmd(4'b0001, 4'b0001);
        repeat (2) @(negedge clk);
        chk(rd_req == 1'b1 && rd_addr == 32'h800, "R10 address held while stalled", longint'(rd_addr), 32'h800);
        cmd(4'b0000, 4'b0001);
        stall = 1'b0;
        wait_idle(0);
        chk(go_cnt[0] == g0, "R7 no transfer after halt", go_cnt[0], g0);
        chk(cur_ptr[31:0] == 32'h800, "R7 pointer kept", longint'(cur_ptr[31:0]), 32'h800);

        // R8: halt during a transfer
        build(32'h900, 3, 30, 0);
        set_hp(0, 32'h900);
        g0 = go_cnt[0];
        cmd(4'b0001, 4'b0001);
        while (go_cnt[0] == g0) @(negedge clk);
        cmd(4'b0000, 4'b0001);
        wait_idle(0);
        chk(go_cnt[0] - g0 == 1, "R8 only current descriptor", go_cnt[0] - g0, 1);
        chk(cur_ptr[31:0] == 32'h900, "R8 pointer kept", longint'(cur_ptr[31:0]), 32'h900);

        // R9: head-pointer write while busy ignored
        build(32'hA00, 2, 10, 0);
        set_hp(0, 32'hA00);
        g0 = go_cnt[0];
        cmd(4'b0001, 4'b0001);
        set_hp(0, 32'hB00);
        wait_idle(0);
        chk(cur_ptr[31:0] == 32'hA14 && go_cnt[0] - g0 == 2, "R9 busy write ignored",
            longint'(cur_ptr[31:0]), 32'hA14);
        set_hp(0, 32'hB00);
        chk(cur_ptr[31:0] == 32'hB00, "R9 idle write taken", longint'(cur_ptr[31:0]), 32'hB00);

        // R10: two channels at once, lower index served first
        build(32'hC00, 2, 6, 4);
        build(32'hD00, 3, 3, 4);
        set_hp(1, 32'hC00);
        set_hp(3, 32'hD00);
        mark = log_n;
        cmd(4'b1010, 4'b1010);
        wait_idle(1);
        wait_idle(3);
        chk(log_a[8'(mark)] == 32'hC00, "R10 lowest channel first", longint'(log_a[8'(mark)]), 32'hC00);
        chk(go_cnt[1] == 2 && go_cnt[3] == 3, "R10 both chains done", go_cnt[1] * 16 + go_cnt[3], 32'h23);
        chk(cur_ptr[63:32] == 32'hC14 && cur_ptr[127:96] == 32'hD28, "R10 final pointers",
            longint'(cur_ptr[127:96]), 32'hD28);
        chk(go_cnt[2] == 0 && cur_ptr[95:64] == 32'h0, "R2 unmasked channel untouched",
            go_cnt[2], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule